// File: doc/BRIEF.md
# Dual-Role USB Control and Interrupt Register File

This block is the software-visible register file of a USB controller that can act as either host or peripheral. It has five 32-bit words on a simple single-cycle bus: control, PHY control, interrupt enable, interrupt flags and a read-only live status word. It drives the control fields towards the role state machine, and it gathers that machine's event pulses and the levels from the bus comparators into sticky flags. A single registered interrupt line reports every flag whose enable bit is set.

The comparator levels (over-current, ID pin, session end, B-valid, A-valid, VBUS-valid) are asynchronous. Each passes through a two-flop synchronizer. A change of level in either direction on the ID, session-end, B-valid, A-valid or VBUS-valid line raises its flag. The two request bits in the control word clear themselves when the protocol no longer allows them. The bus-request bit clears on a drop-VBUS write, on an ID change, on a failed session request and on the wait-for-VBUS-fall entry. The role-swap enable clears on the swap transitions and on a return to idle.

Top module: `dual_role_csr`

## Requirements
- R1: While reset is low and right after it, every register, `ctl_bits`, `phy_bits`, `irq` and `bus_rdata` are zero.
- R2: Byte offsets are 0x00 control, 0x04 PHY control, 0x08 interrupt enable, 0x0C interrupt flags and 0x10 status. Reads are combinational when `bus_vld`=1 and `bus_wr`=0. Any other offset, a write cycle or an idle bus returns 0, and writes to unmapped offsets change nothing.
- R3: Control word fields are drop-VBUS bit 0, bus request bit 1, role-swap enable bit 2, dual-role enable bit 4 and ID wake enable bit 5. All other bits read 0. A write takes effect on the next edge, and `ctl_bits` mirrors bits 5:0.
- R4: A control write with bit 0 set leaves bus request at 0, even if the same write sets bit 1.
- R5: Bus request clears on an ID status toggle, on `fsm_evt[2]` (session request failed) and on `fsm_evt[8]` (entered wait-for-VBUS-fall). A clear in the same cycle as a control write that sets bit 1 wins.
- R6: Role-swap enable clears on `fsm_evt[4]` (return to idle), `fsm_evt[9]` (suspend-to-peripheral on the A side) and `fsm_evt[10]` (peripheral-to-wait-connect on the B side). Other events leave it alone.
- R7: Toggle flags sit at bit 5 for ID, 11 for session end, 8 for B-valid, 9 for A-valid and 10 for VBUS-valid. A flag reads 1 after the third rising edge that follows a change of its input, in either direction. Over-current has no flag.
- R8: Event flags follow `fsm_evt`: bit 0 role change to flag 0, 1 VBUS error to 1, 2 session-request fail to 2, 3 role-swap fail to 3, 4 idle to 4, 5 peripheral to 6, 6 host to 7 and 7 session request seen to 13. Each flag is set on the edge that samples the pulse. Events 8 to 10 set no flag.
- R9: Writing 1 to a flag bit at 0x0C clears it, and writing 0 leaves it. If a set and a clear hit the same bit in one cycle, the bit stays set. Bits 12 and 14 to 31 read 0.
- R10: Enable bits share the positions of their flags, with the same mask 0x2FFF. `irq` is 1 exactly one cycle after some flag and its enable are both 1.
- R11: Status reads over-current at bit 0, ID 1, session end 2, B-valid 3, A-valid 4, VBUS-valid 5, `is_periph` 6 and `is_host` 7. Bits 0 to 5 change after the second rising edge that follows an input change. Writes to 0x10 are ignored.
- R12: PHY control fields are PHY enable bit 0, ID detect enable bit 1, VBUS switch enable polarity bit 4 and switch status polarity bit 5. All other bits read 0, and `phy_bits` mirrors bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_vld | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ovc_in | input | 1 | Over-current level, asynchronous |
| id_in | input | 1 | ID pin level, asynchronous |
| sess_end_in | input | 1 | Session-end level, asynchronous |
| b_valid_in | input | 1 | B-session valid level, asynchronous |
| a_valid_in | input | 1 | A-session valid level, asynchronous |
| vbus_valid_in | input | 1 | VBUS valid level, asynchronous |
| is_host | input | 1 | Role state machine reports host role |
| is_periph | input | 1 | Role state machine reports peripheral role |
| fsm_evt | input | 11 | Single-cycle event pulses from the role state machine |
| ctl_bits | output | 6 | Control word bits 5:0 |
| phy_bits | output | 6 | PHY control word bits 5:0 |
| irq | output | 1 | Registered interrupt request |

## Verification
Reads are due in the same cycle as the request. Register writes and event flags are due one edge later. Status levels are due two edges after an input change, toggle flags three edges after it, and `irq` one edge after the flag it reports. The bench model keeps a three-deep history of the asynchronous inputs, so it reproduces these delays without copying the synchronizer. It compares every output once per clock, after the inputs have settled and before the next edge, so each result is checked in the cycle it falls due and in every cycle after.

// File: rtl/dr_csr_pkg.sv
package dr_csr_pkg;

    localparam int REG_W = 32;

    // byte offsets of the five words
    localparam int OFF_CTL  = 'h00;
    localparam int OFF_PHY  = 'h04;
    localparam int OFF_IEN  = 'h08;
    localparam int OFF_IFLG = 'h0C;
    localparam int OFF_STAT = 'h10;

    typedef enum logic [2:0] {
        SEL_CTL,
        SEL_PHY,
        SEL_IEN,
        SEL_IFLG,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    // control word fields
    localparam int CB_DROP  = 0;
    localparam int CB_BREQ  = 1;
    localparam int CB_SWAP  = 2;
    localparam int CB_DREN  = 4;
    localparam int CB_WAKE  = 5;
    localparam logic [REG_W-1:0] CTL_MASK = REG_W'((1 << CB_DROP) | (1 << CB_BREQ) |
                                                   (1 << CB_SWAP) | (1 << CB_DREN) | (1 << CB_WAKE));

    // PHY control fields
    localparam int PB_PHYEN = 0;
    localparam int PB_IDDET = 1;
    localparam int PB_ENPOL = 4;
    localparam int PB_STPOL = 5;
    localparam logic [REG_W-1:0] PHY_MASK = REG_W'((1 << PB_PHYEN) | (1 << PB_IDDET) |
                                                   (1 << PB_ENPOL) | (1 << PB_STPOL));

    // event pulse indices from the role state machine
    localparam int EV_ROLE   = 0;
    localparam int EV_VBERR  = 1;
    localparam int EV_SRPF   = 2;
    localparam int EV_SWAPF  = 3;
    localparam int EV_IDLE   = 4;
    localparam int EV_PERI   = 5;
    localparam int EV_HOST   = 6;
    localparam int EV_SRPD   = 7;
    localparam int EV_WVFALL = 8;
    localparam int EV_ASWAP  = 9;
    localparam int EV_BSWAP  = 10;
    localparam int EV_W      = 11;

    // asynchronous level indices, equal to their status bit positions
    localparam int AI_OC  = 0;
    localparam int AI_ID  = 1;
    localparam int AI_SE  = 2;
    localparam int AI_BV  = 3;
    localparam int AI_AV  = 4;
    localparam int AI_VBV = 5;
    localparam int AI_W   = 6;

    // interrupt flag positions (shared with the enable word)
    localparam int FL_ROLE  = 0;
    localparam int FL_VBERR = 1;
    localparam int FL_SRPF  = 2;
    localparam int FL_SWAPF = 3;
    localparam int FL_IDLE  = 4;
    localparam int FL_ID    = 5;
    localparam int FL_PERI  = 6;
    localparam int FL_HOST  = 7;
    localparam int FL_BV    = 8;
    localparam int FL_AV    = 9;
    localparam int FL_VBV   = 10;
    localparam int FL_SE    = 11;
    localparam int FL_SRPD  = 13;
    localparam logic [REG_W-1:0] IRQ_MASK = REG_W'(32'h0000_2FFF);

endpackage

// File: rtl/dr_sync_toggle.sv
module dr_sync_toggle #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] toggle
);
    localparam int DEPTH = STAGES + 1;

    // pipe[0] is the first capture flop, pipe[STAGES] holds the previous level
    logic [DEPTH-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[DEPTH-2:0], din};
        end
    end

    assign level  = pipe[STAGES-1];
    assign toggle = pipe[STAGES-1] ^ pipe[STAGES];
endmodule

// File: rtl/dr_ctl_regs.sv
module dr_ctl_regs
    import dr_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_phy,
    input  logic             wr_ien,
    input  logic [REG_W-1:0] wdata,
    input  logic             breq_clr,
    input  logic             swap_clr,
    output logic [REG_W-1:0] ctl_q,
    output logic [REG_W-1:0] phy_q,
    output logic [REG_W-1:0] ien_q
);
    logic [REG_W-1:0] ctl_nxt;

    // software write first, then hardware self-clears take priority
    always_comb begin
        ctl_nxt = ctl_q;
        if (wr_ctl) begin
            ctl_nxt = wdata & CTL_MASK;
            if (wdata[CB_DROP]) begin
                ctl_nxt[CB_BREQ] = 1'b0;
            end
        end
        if (breq_clr) begin
            ctl_nxt[CB_BREQ] = 1'b0;
        end
        if (swap_clr) begin
            ctl_nxt[CB_SWAP] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            phy_q <= '0;
            ien_q <= '0;
        end else begin
            ctl_q <= ctl_nxt;
            if (wr_phy) begin
                phy_q <= wdata & PHY_MASK;
            end
            if (wr_ien) begin
                ien_q <= wdata & IRQ_MASK;
            end
        end
    end
endmodule

// File: rtl/dr_irq_flags.sv
module dr_irq_flags #(
    parameter int          WIDTH = 32,
    parameter logic [31:0] MASK  = 32'h0000_2FFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    input  logic [WIDTH-1:0] en_vec,
    output logic [WIDTH-1:0] flag_q,
    output logic             irq_q
);
    logic [WIDTH-1:0] flag_nxt;

    // per bit: an implemented bit holds, clears on write-one and sets with priority
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (MASK[b]) begin : g_live
            assign flag_nxt[b] = set_vec[b] | (flag_q[b] & ~clr_vec[b]);
        end else begin : g_tied
            assign flag_nxt[b] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_nxt;
            irq_q  <= |(flag_q & en_vec);
        end
    end
endmodule

// File: rtl/dual_role_csr.sv
module dual_role_csr
    import dr_csr_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_vld,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ovc_in,
    input  logic              id_in,
    input  logic              sess_end_in,
    input  logic              b_valid_in,
    input  logic              a_valid_in,
    input  logic              vbus_valid_in,
    input  logic              is_host,
    input  logic              is_periph,
    input  logic [10:0]       fsm_evt,
    output logic [5:0]        ctl_bits,
    output logic [5:0]        phy_bits,
    output logic              irq
);
    reg_sel_e         sel;
    logic             wr_hit;
    logic             rd_hit;
    logic [AI_W-1:0]  ain;
    logic [AI_W-1:0]  ain_lvl;
    logic [AI_W-1:0]  ain_tog;
    logic             unused_oc_tog;
    logic [REG_W-1:0] flag_set;
    logic [REG_W-1:0] flag_clr;
    logic [REG_W-1:0] flag_q;
    logic [REG_W-1:0] ctl_q;
    logic [REG_W-1:0] phy_q;
    logic [REG_W-1:0] ien_q;
    logic [REG_W-1:0] stat_word;
    logic             breq_clr;
    logic             swap_clr;

    // address decode
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFF_CTL):  sel = SEL_CTL;
            ADDR_W'(OFF_PHY):  sel = SEL_PHY;
            ADDR_W'(OFF_IEN):  sel = SEL_IEN;
            ADDR_W'(OFF_IFLG): sel = SEL_IFLG;
            ADDR_W'(OFF_STAT): sel = SEL_STAT;
            default:           sel = SEL_NONE;
        endcase
    end

    assign wr_hit = bus_vld & bus_wr;
    assign rd_hit = bus_vld & ~bus_wr;

    // asynchronous levels, packed in status bit order
    assign ain = {vbus_valid_in, a_valid_in, b_valid_in, sess_end_in, id_in, ovc_in};

    dr_sync_toggle #(
        .WIDTH (AI_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ain),
        .level (ain_lvl),
        .toggle(ain_tog)
    );

    assign unused_oc_tog = ain_tog[AI_OC];

    // flag set sources
    always_comb begin
        flag_set           = '0;
        flag_set[FL_ROLE]  = fsm_evt[EV_ROLE];
        flag_set[FL_VBERR] = fsm_evt[EV_VBERR];
        flag_set[FL_SRPF]  = fsm_evt[EV_SRPF];
        flag_set[FL_SWAPF] = fsm_evt[EV_SWAPF];
        flag_set[FL_IDLE]  = fsm_evt[EV_IDLE];
        flag_set[FL_PERI]  = fsm_evt[EV_PERI];
        flag_set[FL_HOST]  = fsm_evt[EV_HOST];
        flag_set[FL_SRPD]  = fsm_evt[EV_SRPD];
        flag_set[FL_ID]    = ain_tog[AI_ID];
        flag_set[FL_SE]    = ain_tog[AI_SE];
        flag_set[FL_BV]    = ain_tog[AI_BV];
        flag_set[FL_AV]    = ain_tog[AI_AV];
        flag_set[FL_VBV]   = ain_tog[AI_VBV];
    end

    assign flag_clr = (wr_hit && sel == SEL_IFLG) ? bus_wdata : '0;

    // self-clear conditions of the request bits
    assign breq_clr = ain_tog[AI_ID] | fsm_evt[EV_SRPF] | fsm_evt[EV_WVFALL];
    assign swap_clr = fsm_evt[EV_IDLE] | fsm_evt[EV_ASWAP] | fsm_evt[EV_BSWAP];

    dr_ctl_regs u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (wr_hit && sel == SEL_CTL),
        .wr_phy  (wr_hit && sel == SEL_PHY),
        .wr_ien  (wr_hit && sel == SEL_IEN),
        .wdata   (bus_wdata),
        .breq_clr(breq_clr),
        .swap_clr(swap_clr),
        .ctl_q   (ctl_q),
        .phy_q   (phy_q),
        .ien_q   (ien_q)
    );

    dr_irq_flags #(
        .WIDTH(REG_W),
        .MASK (IRQ_MASK)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(flag_set),
        .clr_vec(flag_clr),
        .en_vec (ien_q),
        .flag_q (flag_q),
        .irq_q  (irq)
    );

    assign stat_word = {{(REG_W-8){1'b0}}, is_host, is_periph, ain_lvl};

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (sel)
                SEL_CTL:  bus_rdata = ctl_q;
                SEL_PHY:  bus_rdata = phy_q;
                SEL_IEN:  bus_rdata = ien_q;
                SEL_IFLG: bus_rdata = flag_q;
                SEL_STAT: bus_rdata = stat_word;
                SEL_NONE: bus_rdata = '0;
            endcase
        end
    end

    assign ctl_bits = ctl_q[5:0];
    assign phy_bits = phy_q[5:0];
endmodule

// File: rtl/dual_role_csr_chk.sv
module dual_role_csr_chk
    import dr_csr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_vld,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [10:0]       fsm_evt,
    input logic [5:0]        ctl_bits,
    input logic              irq,
    input logic [31:0]       flags,
    input logic [31:0]       en,
    input logic [31:0]       set_vec
);
    logic wr_ctl_seen;
    logic wr_flg_seen;

    assign wr_ctl_seen = bus_vld && bus_wr && (bus_addr == ADDR_W'(OFF_CTL));
    assign wr_flg_seen = bus_vld && bus_wr && (bus_addr == ADDR_W'(OFF_IFLG));

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flags & $past(set_vec)) == ($past(set_vec) & IRQ_MASK))); // R9

    AST_W1C_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flg_seen |=> ((flags & $past(bus_wdata & ~set_vec)) == 32'h0)); // R9

    AST_DROP_KILLS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl_seen && bus_wdata[CB_DROP]) |=> !ctl_bits[CB_BREQ]); // R4

    AST_REQ_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_evt[EV_SRPF] || fsm_evt[EV_WVFALL]) |=> !ctl_bits[CB_BREQ]); // R5

    AST_SWAP_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_evt[EV_IDLE] || fsm_evt[EV_ASWAP] || fsm_evt[EV_BSWAP]) |=> !ctl_bits[CB_SWAP]); // R6

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 32'h0) |=> !irq); // R10
endmodule

bind dual_role_csr dual_role_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_vld  (bus_vld),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .fsm_evt  (fsm_evt),
    .ctl_bits (ctl_bits),
    .irq      (irq),
    .flags    (flag_q),
    .en       (ien_q),
    .set_vec  (flag_set)
);

// File: tb/dual_role_csr_tb_top.sv
module dual_role_csr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_vld = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  ain = '0;
    logic        is_host = 1'b0;
    logic        is_periph = 1'b0;
    logic [10:0] fsm_evt = '0;
    logic [5:0]  ctl_bits;
    logic [5:0]  phy_bits;
    logic        irq;

    int    n_vec = 0;
    int    n_bad = 0;
    int    rot = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    dual_role_csr dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_vld      (bus_vld),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ovc_in       (ain[0]),
        .id_in        (ain[1]),
        .sess_end_in  (ain[2]),
        .b_valid_in   (ain[3]),
        .a_valid_in   (ain[4]),
        .vbus_valid_in(ain[5]),
        .is_host      (is_host),
        .is_periph    (is_periph),
        .fsm_evt      (fsm_evt),
        .ctl_bits     (ctl_bits),
        .phy_bits     (phy_bits),
        .irq          (irq)
    );

    // behavioural reference state
    logic [31:0] m_ctl = '0, m_phy = '0, m_en = '0, m_flg = '0;
    logic        m_irq = 1'b0;
    logic [5:0]  hist[$] = '{6'h0, 6'h0, 6'h0};

    always @(posedge clk) begin
        logic [5:0]  tg;
        logic [31:0] sets, clr;
        logic        w, nirq;
        if (!rst_n) begin
            m_ctl = '0; m_phy = '0; m_en = '0; m_flg = '0; m_irq = 1'b0;
            hist = '{6'h0, 6'h0, 6'h0};
        end else begin
            tg = hist[1] ^ hist[2];
            sets = '0;
            sets[0] = fsm_evt[0];  sets[1] = fsm_evt[1];  sets[2] = fsm_evt[2];
            sets[3] = fsm_evt[3];  sets[4] = fsm_evt[4];  sets[6] = fsm_evt[5];
            sets[7] = fsm_evt[6];  sets[13] = fsm_evt[7];
            sets[5] = tg[1];  sets[11] = tg[2];  sets[8] = tg[3];
            sets[9] = tg[4];  sets[10] = tg[5];
            w = bus_vld && bus_wr;
            clr = (w && bus_addr == 5'h0C) ? bus_wdata : 32'h0;
            nirq = |(m_flg & m_en);
            m_flg = ((m_flg & ~clr) | sets) & 32'h2FFF;
            if (w && bus_addr == 5'h00) begin
                m_ctl = bus_wdata & 32'h37;
                if (bus_wdata[0]) m_ctl[1] = 1'b0;
            end
            if (tg[1] || fsm_evt[2] || fsm_evt[8]) m_ctl[1] = 1'b0;
            if (fsm_evt[4] || fsm_evt[9] || fsm_evt[10]) m_ctl[2] = 1'b0;
            if (w && bus_addr == 5'h04) m_phy = bus_wdata & 32'h33;
            if (w && bus_addr == 5'h08) m_en = bus_wdata & 32'h2FFF;
            m_irq = nirq;
            hist.push_front(ain);
            void'(hist.pop_back());
        end
    end

    function automatic logic [31:0] exp_rdata();
        if (!(bus_vld && !bus_wr)) return 32'h0;
        case (bus_addr)
            5'h00:   return m_ctl;
            5'h04:   return m_phy;
            5'h08:   return m_en;
            5'h0C:   return m_flg;
            5'h10:   return {24'h0, is_host, is_periph, hist[1]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, after inputs settle and before the next edge
    always @(negedge clk) begin
        #3;
        cmp("rdata", bus_rdata, exp_rdata());
        cmp("irq", {31'h0, irq}, {31'h0, m_irq});
        cmp("ctl_bits", {26'h0, ctl_bits}, {26'h0, m_ctl[5:0]});
        cmp("phy_bits", {26'h0, phy_bits}, {26'h0, m_phy[5:0]});
    end

    task automatic drive(logic v, logic wr, logic [4:0] a, logic [31:0] d, logic [10:0] e);
        @(negedge clk);
        bus_vld = v; bus_wr = wr; bus_addr = a; bus_wdata = d; fsm_evt = e;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            drive(1'b1, 1'b0, 5'(rot * 4), 32'h0, 11'h0);
            rot = (rot + 1) % 5;
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        drive(1'b1, 1'b1, a, d, 11'h0);
    endtask

    task automatic evt(logic [10:0] e);
        drive(1'b1, 1'b0, 5'(rot * 4), 32'h0, e);
        rot = (rot + 1) % 5;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        tag = "R1";
        idle(5);
        rst_n = 1'b1;
        idle(6);

        // R2: unmapped offsets, idle bus, write-cycle data
        tag = "R2";
        drive(1'b1, 1'b0, 5'h14, 32'h0, 11'h0);
        drive(1'b1, 1'b0, 5'h1C, 32'h0, 11'h0);
        drive(1'b1, 1'b0, 5'h02, 32'h0, 11'h0);
        drive(1'b0, 1'b0, 5'h00, 32'h0, 11'h0);
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h0D, 32'hFFFF_FFFF);
        idle(6);

        // R12: PHY control fields
        tag = "R12";
        wr(5'h04, 32'hFFFF_FFFF);
        idle(5);
        wr(5'h04, 32'h0000_0012);
        idle(5);

        // R3: control fields
        tag = "R3";
        wr(5'h00, 32'hFFFF_FFFE);
        idle(5);
        wr(5'h00, 32'h0000_0030);
        idle(3);

        // R4: drop-VBUS kills bus request
        tag = "R4";
        wr(5'h00, 32'h0000_0036);
        idle(2);
        wr(5'h00, 32'h0000_0003);
        idle(5);
        wr(5'h00, 32'h0000_0002);
        idle(2);

        // R5: bus request self-clears
        tag = "R5";
        drive(1'b1, 1'b1, 5'h00, 32'h0000_0006, 11'h004);
        idle(2);
        wr(5'h00, 32'h0000_0006);
        evt(11'h004);
        idle(2);
        wr(5'h00, 32'h0000_0006);
        evt(11'h100);
        idle(2);
        wr(5'h00, 32'h0000_0006);
        evt(11'h200);
        idle(2);
        wr(5'h00, 32'h0000_0006);
        ain[1] = 1'b1;
        idle(6);
        wr(5'h00, 32'h0000_0006);
        ain[1] = 1'b0;
        idle(6);

        // R6: role-swap enable self-clears
        tag = "R6";
        wr(5'h00, 32'h0000_0004);
        evt(11'h010);
        wr(5'h00, 32'h0000_0004);
        evt(11'h200);
        wr(5'h00, 32'h0000_0004);
        evt(11'h400);
        wr(5'h00, 32'h0000_0004);
        evt(11'h008);
        evt(11'h100);
        idle(3);

        // R7: toggle flags, both directions
        tag = "R7";
        wr(5'h0C, 32'hFFFF_FFFF);
        for (int k = 0; k < 6; k++) begin
            ain[k] = 1'b1;
            idle(5);
            ain[k] = 1'b0;
            idle(5);
            wr(5'h0C, 32'hFFFF_FFFF);
            idle(2);
        end
        ain = 6'h3F;
        idle(5);
        wr(5'h0C, 32'hFFFF_FFFF);
        ain = 6'h00;
        idle(6);

        // R8: event flags
        tag = "R8";
        wr(5'h0C, 32'hFFFF_FFFF);
        for (int k = 0; k < 11; k++) begin
            evt(11'(1 << k));
            idle(2);
        end

        // R9: write-one-to-clear and set priority
        tag = "R9";
        wr(5'h0C, 32'h0000_0000);
        idle(2);
        wr(5'h0C, 32'h0000_0041);
        idle(2);
        drive(1'b1, 1'b1, 5'h0C, 32'hFFFF_FFFF, 11'h001);
        idle(2);
        wr(5'h0C, 32'hFFFF_FFFF);
        idle(2);

        // R10: enables and registered interrupt
        tag = "R10";
        wr(5'h08, 32'hFFFF_FFFF);
        idle(3);
        evt(11'h040);
        idle(3);
        wr(5'h0C, 32'h0000_0080);
        idle(3);
        wr(5'h08, 32'h0000_0000);
        evt(11'h0FF);
        idle(3);
        wr(5'h08, 32'h0000_2000);
        idle(3);
        wr(5'h08, 32'h0000_1000);
        idle(3);
        wr(5'h0C, 32'hFFFF_FFFF);
        idle(3);

        // R11: status word, read-only
        tag = "R11";
        wr(5'h10, 32'hFFFF_FFFF);
        idle(3);
        ain = 6'h2A;
        is_host = 1'b1;
        idle(5);
        is_host = 1'b0;
        is_periph = 1'b1;
        ain = 6'h15;
        idle(5);
        is_periph = 1'b0;
        ain = 6'h00;
        idle(6);

        finish_run();
    end
endmodule